// File: doc/BRIEF.md
# Two-Floor Lift Sequencer

This block sequences a lift that serves two floors. It reads eight pins: a landing call button and an in-car button for each floor, a limit switch that reports the car level with each floor, a switch that reports the door fully shut, and a sensor that reports something in the doorway. It drives four outputs: hoist up, hoist down, door open and door close. Every pin passes through a two-flop synchroniser before any decision uses it.

The sequence is held in eight one-hot flip-flops, one per state. Each bit is set when its entry condition holds in the state before it. It is cleared when one of its successors is set. The outputs are ORs of state bits, and the hoist outputs are also gated by the synchronised door-shut switch. A closing state moves to one of two successors: an obstructed-hold state or a travel state. In the obstructed-hold state the door is re-opened and a retry timer runs for `CLK_HZ * RETRY_SEC` clock cycles. When the timer expires, the sequencer tries to close the door again.

State numbering (bit index of the one-hot register): 0 travelling down, 1 parked at floor 1 door open, 2 closing to go up, 3 obstructed before going up, 4 travelling up, 5 parked at floor 2 door open, 6 closing to go down, 7 obstructed before going down.

Top module: `lift_top`

## Requirements
- R1: After reset the lift is parked at floor 1 with the door open: doorOpen = 1 and doorClose, motorUp, motorDown = 0.
- R2: While the door is open at a floor, a call or car button for the other floor starts closing: doorClose = 1, doorOpen = 0. A button for the floor the car is parked at has no effect, and the door stays open.
- R3: While closing, an active obstruction re-opens the door (doorOpen = 1, doorClose = 0). This applies even when the door-shut switch is active in the same cycle. doorOpen and doorClose are never both 1.
- R4: The obstructed-hold state lasts exactly CLK_HZ*RETRY_SEC cycles. After that, doorClose is asserted again whatever the obstruction pin does during the hold.
- R5: When closing and the door-shut switch is active with no obstruction, the car starts to travel. A hoist output is 1 only while the synchronised door-shut switch is 1, and motorUp and motorDown are never both 1.
- R6: While travelling, the limit switch of the target floor stops the hoist and opens the door at that floor.
- R7: Exactly one state flip-flop is set in every cycle after reset.
- R8: Every pin goes through two synchronising flops. A pin change alters a state-driven output 3 clock edges later, and alters the hoist gating by the door-shut switch 2 edges later.
- R9: The downward trip from floor 2 (request, closing, obstructed hold with retry, travel down, stop at floor 1) mirrors the upward trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | asynchronous active-low reset |
| callFloor1 | input | 1 | landing call button, floor 1 |
| callFloor2 | input | 1 | landing call button, floor 2 |
| carFloor1 | input | 1 | in-car button for floor 1 |
| carFloor2 | input | 1 | in-car button for floor 2 |
| limitFloor1 | input | 1 | car level with floor 1 |
| limitFloor2 | input | 1 | car level with floor 2 |
| doorShut | input | 1 | door fully shut switch |
| doorBlocked | input | 1 | doorway obstruction sensor |
| motorUp | output | 1 | hoist drive upward |
| motorDown | output | 1 | hoist drive downward |
| doorOpen | output | 1 | door operator open command |
| doorClose | output | 1 | door operator close command |

## Verification
A pin change passes two synchroniser flops and then the state register, so doorOpen and doorClose move on the third clock edge after the change. The directed checks sample one edge early and again on that third edge. The hoist outputs follow a door-shut change after two edges because only the synchroniser lies in that path. The retry is checked on the last cycle of the hold and on the cycle after it. A behavioural reference model with its own synchroniser delay line and hold counter predicts all four outputs. Its predictions are compared with the outputs at every falling edge.

// File: rtl/lift_pkg.sv
package lift_pkg;

  localparam int NUM_STATES = 8;
  localparam int NUM_PINS   = 8;

  // one-hot bit positions; doorOpen decodes the odd ones
  localparam int ST_DOWN_RUN  = 0;
  localparam int ST_F1_OPEN   = 1;
  localparam int ST_UP_SHUT   = 2;
  localparam int ST_UP_HOLD   = 3;
  localparam int ST_UP_RUN    = 4;
  localparam int ST_F2_OPEN   = 5;
  localparam int ST_DOWN_SHUT = 6;
  localparam int ST_DOWN_HOLD = 7;

  typedef struct packed {
    logic call1;
    logic call2;
    logic car1;
    logic car2;
    logic lim1;
    logic lim2;
    logic shut;
    logic blocked;
  } liftIn_t;

  // control -> datapath strobes
  typedef struct packed {
    logic holdActive;
  } ctrlStrobe_t;

  // datapath -> control
  typedef struct packed {
    liftIn_t pins;
    logic    retryDue;
  } dpStatus_t;

endpackage

// File: rtl/lift_sync.sv
module lift_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe <= '0;
        else       pipe <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe <= '0;
        else       pipe <= {pipe[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/lift_datapath.sv
module lift_datapath
  import lift_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 100_000_000,
  parameter int unsigned RETRY_SEC   = 5,
  parameter int          SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  liftIn_t     rawPins,
  input  ctrlStrobe_t strobe,
  output dpStatus_t   status
);
  localparam int unsigned RETRY_CYCLES = CLK_HZ * RETRY_SEC;
  localparam int CNT_W = (RETRY_CYCLES > 1) ? $clog2(RETRY_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(RETRY_CYCLES - 1);

  logic [NUM_PINS-1:0] rawVec;
  logic [NUM_PINS-1:0] syncVec;
  logic [CNT_W-1:0]    holdCnt;
  logic                holdDone;

  assign rawVec = rawPins;

  generate
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_sync
      lift_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rstN(rstN),
        .d   (rawVec[i]),
        .q   (syncVec[i])
      );
    end
  endgenerate

  // retry timer: cleared outside a hold state, counts up while in one
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= '0;
    end else if (!strobe.holdActive) begin
      holdCnt <= '0;
    end else if (holdCnt != LAST_TICK) begin
      holdCnt <= holdCnt + 1'b1;
    end
  end

  assign holdDone = strobe.holdActive && (holdCnt == LAST_TICK);

  assign status.pins     = syncVec;
  assign status.retryDue = holdDone;
endmodule

// File: rtl/lift_control.sv
module lift_control
  import lift_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStatus_t             status,
  output ctrlStrobe_t           strobe,
  output logic [NUM_STATES-1:0] stateQ,
  output logic                  motorUp,
  output logic                  motorDown,
  output logic                  doorOpen,
  output logic                  doorClose
);
  logic [NUM_STATES-1:0] setV;
  logic [NUM_STATES-1:0] leaveV;
  logic reqUp, reqDown, blocked, shut, goRun;

  assign reqUp   = status.pins.call2 | status.pins.car2;
  assign reqDown = status.pins.call1 | status.pins.car1;
  assign blocked = status.pins.blocked;
  assign shut    = status.pins.shut;
  assign goRun   = shut & ~blocked;

  // entry conditions of each state
  always_comb begin
    setV = '0;
    setV[ST_UP_SHUT]   = (stateQ[ST_F1_OPEN] & reqUp)
                       | (stateQ[ST_UP_HOLD] & status.retryDue);
    setV[ST_UP_HOLD]   = stateQ[ST_UP_SHUT] & blocked;
    setV[ST_UP_RUN]    = stateQ[ST_UP_SHUT] & goRun;
    setV[ST_F2_OPEN]   = stateQ[ST_UP_RUN] & status.pins.lim2;
    setV[ST_DOWN_SHUT] = (stateQ[ST_F2_OPEN] & reqDown)
                       | (stateQ[ST_DOWN_HOLD] & status.retryDue);
    setV[ST_DOWN_HOLD] = stateQ[ST_DOWN_SHUT] & blocked;
    setV[ST_DOWN_RUN]  = stateQ[ST_DOWN_SHUT] & goRun;
    setV[ST_F1_OPEN]   = stateQ[ST_DOWN_RUN] & status.pins.lim1;
  end

  // exit conditions: the union of the successors' entry terms
  always_comb begin
    leaveV = '0;
    leaveV[ST_F1_OPEN]   = reqUp;
    leaveV[ST_UP_SHUT]   = blocked | shut;
    leaveV[ST_UP_HOLD]   = status.retryDue;
    leaveV[ST_UP_RUN]    = status.pins.lim2;
    leaveV[ST_F2_OPEN]   = reqDown;
    leaveV[ST_DOWN_SHUT] = blocked | shut;
    leaveV[ST_DOWN_HOLD] = status.retryDue;
    leaveV[ST_DOWN_RUN]  = status.pins.lim1;
  end

  generate
    for (genvar s = 0; s < NUM_STATES; s++) begin : g_state
      localparam logic RESET_VAL = (s == ST_F1_OPEN);
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stateQ[s] <= RESET_VAL;
        else       stateQ[s] <= setV[s] | (stateQ[s] & ~leaveV[s]);
      end
    end
  endgenerate

  assign strobe.holdActive = stateQ[ST_UP_HOLD] | stateQ[ST_DOWN_HOLD];

  assign doorOpen  = stateQ[ST_F1_OPEN] | stateQ[ST_UP_HOLD]
                   | stateQ[ST_F2_OPEN] | stateQ[ST_DOWN_HOLD];
  assign doorClose = stateQ[ST_UP_SHUT] | stateQ[ST_DOWN_SHUT];
  assign motorUp   = stateQ[ST_UP_RUN]   & shut;
  assign motorDown = stateQ[ST_DOWN_RUN] & shut;
endmodule

// File: rtl/lift_top.sv
module lift_top
  import lift_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 100_000_000,
  parameter int unsigned RETRY_SEC   = 5,
  parameter int          SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic callFloor1,
  input  logic callFloor2,
  input  logic carFloor1,
  input  logic carFloor2,
  input  logic limitFloor1,
  input  logic limitFloor2,
  input  logic doorShut,
  input  logic doorBlocked,
  output logic motorUp,
  output logic motorDown,
  output logic doorOpen,
  output logic doorClose
);
  liftIn_t               rawPins;
  ctrlStrobe_t           strobe;
  dpStatus_t             dpStat;
  logic [NUM_STATES-1:0] stateQ;

  always_comb begin
    rawPins.call1   = callFloor1;
    rawPins.call2   = callFloor2;
    rawPins.car1    = carFloor1;
    rawPins.car2    = carFloor2;
    rawPins.lim1    = limitFloor1;
    rawPins.lim2    = limitFloor2;
    rawPins.shut    = doorShut;
    rawPins.blocked = doorBlocked;
  end

  lift_datapath #(
    .CLK_HZ     (CLK_HZ),
    .RETRY_SEC  (RETRY_SEC),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .rawPins(rawPins),
    .strobe (strobe),
    .status (dpStat)
  );

  lift_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .status   (dpStat),
    .strobe   (strobe),
    .stateQ   (stateQ),
    .motorUp  (motorUp),
    .motorDown(motorDown),
    .doorOpen (doorOpen),
    .doorClose(doorClose)
  );
endmodule

// File: rtl/lift_checker.sv
module lift_checker
  import lift_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic [NUM_STATES-1:0] stateQ,
  input dpStatus_t             dpStat,
  input logic                  motorUp,
  input logic                  motorDown,
  input logic                  doorOpen,
  input logic                  doorClose
);
  AST_ONE_HOT: assert property (@(posedge clk) disable iff (!rstN)
    $countones(stateQ) == 1); // R7

  AST_MOTOR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(motorUp && motorDown)); // R5

  AST_MOTOR_NEEDS_SHUT: assert property (@(posedge clk) disable iff (!rstN)
    (motorUp || motorDown) |-> dpStat.pins.shut); // R5

  AST_DOOR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(doorOpen && doorClose)); // R3

  AST_RETRY_CLOSE: assert property (@(posedge clk) disable iff (!rstN)
    dpStat.retryDue |=> doorClose); // R4

  AST_LIMIT_STOP_UP: assert property (@(posedge clk) disable iff (!rstN)
    (motorUp && dpStat.pins.lim2) |=> (!motorUp && doorOpen)); // R6

  AST_LIMIT_STOP_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (motorDown && dpStat.pins.lim1) |=> (!motorDown && doorOpen)); // R6

  AST_OWN_FLOOR_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ[ST_F1_OPEN] && !dpStat.pins.call2 && !dpStat.pins.car2)
      |=> (doorOpen && !doorClose)); // R2
endmodule

bind lift_top lift_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .stateQ   (stateQ),
  .dpStat   (dpStat),
  .motorUp  (motorUp),
  .motorDown(motorDown),
  .doorOpen (doorOpen),
  .doorClose(doorClose)
);

// File: tb/test_lift_top.sv
`timescale 1ns/1ps
module test_lift_top;
  localparam int HZ    = 4;
  localparam int SEC   = 5;
  localparam int HOLDN = HZ * SEC;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic callFloor1 = 0, callFloor2 = 0, carFloor1 = 0, carFloor2 = 0;
  logic limitFloor1 = 1, limitFloor2 = 0, doorShut = 0, doorBlocked = 0;
  logic motorUp, motorDown, doorOpen, doorClose;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  lift_top #(.CLK_HZ(HZ), .RETRY_SEC(SEC), .SYNC_STAGES(2)) i_lift_top (
    .clk(clk), .rstN(rstN),
    .callFloor1(callFloor1), .callFloor2(callFloor2),
    .carFloor1(carFloor1), .carFloor2(carFloor2),
    .limitFloor1(limitFloor1), .limitFloor2(limitFloor2),
    .doorShut(doorShut), .doorBlocked(doorBlocked),
    .motorUp(motorUp), .motorDown(motorDown),
    .doorOpen(doorOpen), .doorClose(doorClose)
  );

  // ---------------- behavioural reference model ----------------
  typedef enum int {M_DOWN, M_AT1, M_CLOSE_UP, M_WAIT_UP, M_UP,
                    M_AT2, M_CLOSE_DN, M_WAIT_DN} mState_e;
  mState_e ms;
  int holdCount;
  // delay line of pin samples: index 0 newest, index 1 what the logic sees
  logic [7:0] seen [2];

  function automatic logic [7:0] pinsNow();
    return {callFloor1, callFloor2, carFloor1, carFloor2,
            limitFloor1, limitFloor2, doorShut, doorBlocked};
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ms = M_AT1; holdCount = 0; seen[0] = '0; seen[1] = '0;
    end else begin
      logic c1, c2, k1, k2, l1, l2, sh, bl;
      {c1, c2, k1, k2, l1, l2, sh, bl} = seen[1];
      case (ms)
        M_AT1:      if (c2 || k2) ms = M_CLOSE_UP;
        M_CLOSE_UP: if (bl) begin ms = M_WAIT_UP; holdCount = 0; end
                    else if (sh) ms = M_UP;
        M_WAIT_UP:  begin holdCount++; if (holdCount == HOLDN) ms = M_CLOSE_UP; end
        M_UP:       if (l2) ms = M_AT2;
        M_AT2:      if (c1 || k1) ms = M_CLOSE_DN;
        M_CLOSE_DN: if (bl) begin ms = M_WAIT_DN; holdCount = 0; end
                    else if (sh) ms = M_DOWN;
        M_WAIT_DN:  begin holdCount++; if (holdCount == HOLDN) ms = M_CLOSE_DN; end
        M_DOWN:     if (l1) ms = M_AT1;
        default:    ms = M_AT1;
      endcase
      seen[1] = seen[0];
      seen[0] = pinsNow();
    end
  end

  task automatic check(input string tag, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at cycle %0d", tag, what, got, exp, cycles);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      logic eOpen, eClose, eUp, eDown;
      eOpen  = (ms == M_AT1) || (ms == M_WAIT_UP) || (ms == M_AT2) || (ms == M_WAIT_DN);
      eClose = (ms == M_CLOSE_UP) || (ms == M_CLOSE_DN);
      eUp    = (ms == M_UP) && seen[1][1];
      eDown  = (ms == M_DOWN) && seen[1][1];
      check("R5", "model motorUp", motorUp, eUp);
      check("R9", "model motorDown", motorDown, eDown);
      check("R3", "model doorOpen", doorOpen, eOpen);
      check("R2", "model doorClose", doorClose, eClose);
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);
    // R1 reset state
    check("R1", "doorOpen", doorOpen, 1'b1);
    check("R1", "doorClose", doorClose, 1'b0);
    check("R1", "motorUp", motorUp, 1'b0);
    check("R1", "motorDown", motorDown, 1'b0);

    // R2 own-floor button ignored
    carFloor1 = 1; callFloor1 = 1;
    step(6);
    check("R2", "own floor doorOpen", doorOpen, 1'b1);
    check("R2", "own floor doorClose", doorClose, 1'b0);
    carFloor1 = 0; callFloor1 = 0;
    step(4);

    // R8 latency: request seen on third edge
    carFloor2 = 1;
    step(2);
    check("R8", "doorClose before 3 edges", doorClose, 1'b0);
    step(1);
    check("R2", "doorClose on request", doorClose, 1'b1);
    check("R2", "doorOpen dropped", doorOpen, 1'b0);
    carFloor2 = 0;

    // R3 obstruction wins over shut in same cycle
    doorBlocked = 1; doorShut = 1; limitFloor1 = 0;
    step(3);
    check("R3", "reopen doorOpen", doorOpen, 1'b1);
    check("R3", "reopen doorClose", doorClose, 1'b0);
    check("R3", "no travel while blocked", motorUp, 1'b0);
    doorBlocked = 0; doorShut = 0;

    // R4 hold length
    step(HOLDN - 1);
    check("R4", "still held", doorOpen, 1'b1);
    step(1);
    check("R4", "retry close", doorClose, 1'b1);

    // R5 start travel, R8 gating latency
    doorShut = 1;
    step(2);
    check("R5", "no motor yet", motorUp, 1'b0);
    step(1);
    check("R5", "motorUp on", motorUp, 1'b1);
    check("R5", "doorClose off", doorClose, 1'b0);
    doorShut = 0;
    step(1);
    check("R8", "motor still on 1 edge", motorUp, 1'b1);
    step(1);
    check("R5", "motor gated by shut", motorUp, 1'b0);
    doorShut = 1;
    step(2);
    check("R5", "motor resumes", motorUp, 1'b1);

    // R6 stop at floor 2
    limitFloor2 = 1;
    step(2);
    check("R6", "still moving", motorUp, 1'b1);
    step(1);
    check("R6", "stopped at 2", motorUp, 1'b0);
    check("R6", "door opens at 2", doorOpen, 1'b1);
    doorShut = 0;
    step(4);

    // R9 downward trip
    callFloor1 = 1;
    step(3);
    check("R9", "closing to go down", doorClose, 1'b1);
    callFloor1 = 0;
    doorBlocked = 1;
    step(3);
    check("R9", "obstructed going down", doorOpen, 1'b1);
    doorBlocked = 0;
    step(HOLDN - 1);
    check("R4", "down hold still open", doorOpen, 1'b1);
    step(1);
    check("R4", "down retry close", doorClose, 1'b1);
    limitFloor2 = 0; doorShut = 1;
    step(3);
    check("R9", "motorDown on", motorDown, 1'b1);
    check("R5", "motorUp off going down", motorUp, 1'b0);
    limitFloor1 = 1;
    step(3);
    check("R6", "stopped at 1", motorDown, 1'b0);
    check("R6", "door opens at 1", doorOpen, 1'b1);
    doorShut = 0;

    // R2 own floor again
    callFloor1 = 1;
    step(5);
    check("R2", "floor 1 call at floor 1", doorClose, 1'b0);
    callFloor1 = 0;
    step(2);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule